// File: doc/BRIEF.md
# Three-Wire Length-Detecting Serial Loader

This block is the enable-framed serial receiver of a tuning synthesizer's control port. While the enable line is high, it shifts in one bit on each falling edge of the serial clock. It counts both clock edges and decides from the final bit count whether the host sent a short tuning word, a long tuning word or an extended word that also carries control settings. Each output register has its own commit point. The band outputs load early in the frame, the divider word loads at a fixed clock count or at the end of the frame, and the control set loads only when an extended frame closes.

The block owns the shared register set: band outputs, divider word, pump current select, test field, the two ratio bits and the tuning-off flag. A second, two-wire receiver writes the same registers. A bus-select pin decides which receiver sees the pins, and this block reflects that choice on `wire_mode`. The pins are assumed to be synchronised to `clk` upstream, and each level is assumed to hold for at least one clock period.

Top module: `triwire_word_loader`

## Requirements
- R1: A synchronous active-low reset gives the following state: band 0, divider 0, `pump_hi`=1, `test_mode`=3'b001, `ratio_a`=0, `ratio_b`=`RSB_AT_RESET` (default 1), `tune_off`=1.
- R2: While `ce` and `bus_sel` are high, a bit is taken on each falling edge of `scl`, MSB first. The first four bits are the band outputs, with bit 3 sent first. They load on the fifth rising `scl` edge of the frame. At no other time do the band outputs change.
- R3: A frame of exactly 18 bits is closed by `ce` falling. At that point the divider becomes {0, the 14 bits that followed the band bits} and `ratio_a` becomes 1.
- R4: A frame of exactly 19 bits is closed by `ce` falling. At that point the divider becomes the 15 bits that followed the band bits and `ratio_a` becomes 0.
- R5: In any frame, the 20th rising `scl` edge loads the divider from bits 5 to 19 of the frame, before the frame ends.
- R6: A frame of exactly 27 bits is closed by `ce` falling. At that point the control set loads from its last eight bits. The first of those bits is ignored. The remaining seven, in order, are `pump_hi`, `test_mode[2]`, `test_mode[1]`, `test_mode[0]`, `ratio_a`, `ratio_b` and `tune_off`.
- R7: A frame of 18 or 19 bits leaves `pump_hi`, `test_mode`, `ratio_b` and `tune_off` unchanged.
- R8: A frame shorter than 18 bits never changes the divider or the control set. Its band bits still load if the fifth rising edge occurred.
- R9: A frame of any other length of 18 bits or more commits nothing at its end. Only the loads already made at the fifth and 20th rising edges remain.
- R10: While `bus_sel` is low, the pins have no effect on any register and `wire_mode` is 0. While `bus_sel` is high, `wire_mode` is 1.
- R11: The reset value of `ratio_b` is the build parameter `RSB_AT_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | High routes the pins to this receiver |
| ce | input | 1 | Frame enable, high during a transfer |
| scl | input | 1 | Serial clock |
| sda | input | 1 | Serial data |
| band_sw | output | 4 | Band switch outputs |
| freq_word | output | 15 | Programmable divider word |
| pump_hi | output | 1 | High charge-pump current select |
| test_mode | output | 3 | Test field |
| ratio_a | output | 1 | Ratio select bit set by frame length |
| ratio_b | output | 1 | Ratio select bit set by extended frames |
| tune_off | output | 1 | Tuning output disable |
| wire_mode | output | 1 | High when this receiver owns the shared registers |

## Verification
The in-line properties check, on every cycle, these rules:
- the band outputs move only at a fifth rising edge;
- the ratio and divider results of 18- and 19-bit frame ends;
- that non-extended frame ends never touch the pump, test, ratio-b or tuning-off fields;
- that the divider holds at ends of frames with other lengths;
- that nothing changes while the other receiver is selected.

Only the bench scenarios can show that bit order and field positions are right, that the 20th-edge divider load arrives before the frame closes, that extended control values persist through later short words, and that short and odd-length frames keep their early band load.

// File: rtl/tw_loader_pkg.sv
// Package: shared types for the three-wire serial loader.
// Assumes: the control field order matches the two-wire receiver's control byte.
package tw_loader_pkg;
    typedef struct packed {
        logic       cp;     // high pump current
        logic [2:0] test;   // test field
        logic       rsa;    // length-driven ratio bit
        logic       rsb;    // extended-only ratio bit
        logic       os;     // tuning output off
    } ctrl_t;
endpackage

// File: rtl/tw_pin_events.sv
// Module: turns sampled pin levels into one-cycle frame events.
// Assumes: pins are already synchronous to clk and each level lasts >= 1 clock.
module tw_pin_events (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ce,
    input  logic scl,
    output logic active,
    output logic fall_ev,
    output logic rise_ev,
    output logic end_ev
);
    logic prev_ce;
    logic prev_scl;

    // Remember last cycle's enable-qualified frame level and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ce  <= 1'b0;
            prev_scl <= 1'b0;
        end else begin
            prev_ce  <= ce & enable;
            prev_scl <= scl;
        end
    end

    // Decode edges inside an active frame and the frame close.
    always_comb begin
        active  = enable & ce;
        fall_ev = active & prev_scl & ~scl;
        rise_ev = active & ~prev_scl & scl;
        end_ev  = enable & prev_ce & ~ce;
    end
endmodule

// File: rtl/tw_frame_counter.sv
// Module: shift register plus saturating counts of falling and rising edges.
// Assumes: counts restart whenever the frame is inactive.
module tw_frame_counter #(
    parameter int SR_W  = 15,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             fall_ev,
    input  logic             rise_ev,
    input  logic             sda,
    output logic [SR_W-1:0]  sr,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] rise_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Shift data in MSB first on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (fall_ev) sr <= {sr[SR_W-2:0], sda};
    end

    // Count bits and rising edges per frame, saturating so long frames never wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt  <= '0;
            rise_cnt <= '0;
        end else begin
            if (fall_ev && bit_cnt != CNT_MAX)  bit_cnt  <= bit_cnt + 1'b1;
            if (rise_ev && rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tw_commit_regs.sv
// Module: holds the shared registers and applies each commit point.
// Assumes: sr holds the most recent SR_W bits; counters show pre-event values.
module tw_commit_regs
    import tw_loader_pkg::*;
#(
    parameter int BS_W         = 4,
    parameter int N_W          = 15,
    parameter int CTRL_W       = 8,
    parameter int CNT_W        = 6,
    parameter bit RSB_AT_RESET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ev,
    input  logic             end_ev,
    input  logic [N_W-1:0]   sr,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [CNT_W-1:0] rise_cnt,
    output logic [BS_W-1:0]  band_q,
    output logic [N_W-1:0]   freq_q,
    output ctrl_t            ctrl_q
);
    localparam int LEN_SHORT = BS_W + N_W - 1;
    localparam int LEN_LONG  = BS_W + N_W;
    localparam int LEN_EXT   = LEN_LONG + CTRL_W;
    localparam logic [CNT_W-1:0] BAND_AT  = CNT_W'(BS_W);      // count before 5th rise
    localparam logic [CNT_W-1:0] FREQ_AT  = CNT_W'(LEN_LONG);  // count before 20th rise
    localparam logic [CNT_W-1:0] C_SHORT  = CNT_W'(LEN_SHORT);
    localparam logic [CNT_W-1:0] C_LONG   = CNT_W'(LEN_LONG);
    localparam logic [CNT_W-1:0] C_EXT    = CNT_W'(LEN_EXT);

    logic band_hit, freq_hit, end_short, end_long, end_ext;

    // Classify the current event against the commit points.
    always_comb begin
        band_hit  = rise_ev && rise_cnt == BAND_AT;
        freq_hit  = rise_ev && rise_cnt == FREQ_AT;
        end_short = end_ev && bit_cnt == C_SHORT;
        end_long  = end_ev && bit_cnt == C_LONG;
        end_ext   = end_ev && bit_cnt == C_EXT;
    end

    // Band outputs load from the first four bits on the fifth rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        band_q <= '0;
        else if (band_hit) band_q <= sr[BS_W-1:0];
    end

    // Divider loads mid-frame for long frames or at close of 18/19-bit frames.
    always_ff @(posedge clk) begin
        if (!rst_n)         freq_q <= '0;
        else if (freq_hit)  freq_q <= sr;
        else if (end_short) freq_q <= {1'b0, sr[N_W-2:0]};
        else if (end_long)  freq_q <= sr;
    end

    // Control set: length sets ratio_a, extended frames set everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.cp   <= 1'b1;
            ctrl_q.test <= 3'b001;
            ctrl_q.rsa  <= 1'b0;
            ctrl_q.rsb  <= RSB_AT_RESET;
            ctrl_q.os   <= 1'b1;
        end else if (end_ext) begin
            ctrl_q <= ctrl_t'(sr[CTRL_W-2:0]);
        end else if (end_short) begin
            ctrl_q.rsa <= 1'b1;
        end else if (end_long) begin
            ctrl_q.rsa <= 1'b0;
        end
    end

    // R2
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_ev && rise_cnt == BAND_AT) |=> $stable(band_q));

    // R3
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ev && bit_cnt == C_SHORT) |=> (ctrl_q.rsa && !freq_q[N_W-1]));

    // R4
    long_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ev && bit_cnt == C_LONG) |=> (!ctrl_q.rsa && freq_q == $past(sr)));

    // R7
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ev && bit_cnt != C_EXT) |=>
            ($stable(ctrl_q.cp) && $stable(ctrl_q.test) && $stable(ctrl_q.rsb) && $stable(ctrl_q.os)));

    // R8
    odd_frame_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ev && bit_cnt != C_SHORT && bit_cnt != C_LONG) |=> $stable(freq_q));
endmodule

// File: rtl/triwire_word_loader.sv
// Module: top of the enable-framed serial loader with word-length detection.
// Assumes: pins are synchronous to clk; when bus_sel is low another receiver owns the pins.
module triwire_word_loader #(
    parameter int BS_W         = 4,
    parameter int N_W          = 15,
    parameter int CTRL_W       = 8,
    parameter bit RSB_AT_RESET = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            ce,
    input  logic            scl,
    input  logic            sda,
    output logic [BS_W-1:0] band_sw,
    output logic [N_W-1:0]  freq_word,
    output logic            pump_hi,
    output logic [2:0]      test_mode,
    output logic            ratio_a,
    output logic            ratio_b,
    output logic            tune_off,
    output logic            wire_mode
);
    import tw_loader_pkg::*;

    localparam int LEN_EXT = BS_W + N_W + CTRL_W;
    localparam int CNT_W   = $clog2(LEN_EXT + 1) + 1;

    logic             active, fall_ev, rise_ev, end_ev;
    logic [N_W-1:0]   sr;
    logic [CNT_W-1:0] bit_cnt, rise_cnt;
    ctrl_t            ctrl_q;

    tw_pin_events u_events (
        .clk(clk), .rst_n(rst_n), .enable(bus_sel), .ce(ce), .scl(scl),
        .active(active), .fall_ev(fall_ev), .rise_ev(rise_ev), .end_ev(end_ev)
    );

    tw_frame_counter #(.SR_W(N_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .active(active), .fall_ev(fall_ev),
        .rise_ev(rise_ev), .sda(sda), .sr(sr), .bit_cnt(bit_cnt), .rise_cnt(rise_cnt)
    );

    tw_commit_regs #(
        .BS_W(BS_W), .N_W(N_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W), .RSB_AT_RESET(RSB_AT_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .end_ev(end_ev), .sr(sr),
        .bit_cnt(bit_cnt), .rise_cnt(rise_cnt), .band_q(band_sw), .freq_q(freq_word),
        .ctrl_q(ctrl_q)
    );

    // Expose control fields and the receiver ownership flag.
    always_comb begin
        pump_hi   = ctrl_q.cp;
        test_mode = ctrl_q.test;
        ratio_a   = ctrl_q.rsa;
        ratio_b   = ctrl_q.rsb;
        tune_off  = ctrl_q.os;
        wire_mode = bus_sel;
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> ($stable(band_sw) && $stable(freq_word) && $stable(ctrl_q)));
endmodule

// File: tb/triwire_word_loader_tb_top.sv
module triwire_word_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b1, ce = 1'b0, scl = 1'b0, sda = 1'b0;
    logic [3:0]  band_sw;
    logic [14:0] freq_word;
    logic [2:0]  test_mode;
    logic pump_hi, ratio_a, ratio_b, tune_off, wire_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    triwire_word_loader #(.RSB_AT_RESET(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .ce(ce), .scl(scl), .sda(sda),
        .band_sw(band_sw), .freq_word(freq_word), .pump_hi(pump_hi), .test_mode(test_mode),
        .ratio_a(ratio_a), .ratio_b(ratio_b), .tune_off(tune_off), .wire_mode(wire_mode)
    );

    // Behavioural reference model
    bit      bits[$];
    int      rises;
    bit      m_pce, m_pscl;
    int      m_band, m_freq, m_cp, m_test, m_rsa, m_rsb, m_os;

    function automatic int take(int first, int count);
        int v = 0;
        for (int k = first; k < first + count; k++) v = (v << 1) | int'(bits[k]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bits.delete(); rises = 0; m_pce = 0; m_pscl = 0;
            m_band = 0; m_freq = 0; m_cp = 1; m_test = 1; m_rsa = 0; m_rsb = 1; m_os = 1;
        end else begin
            if (bus_sel && m_pce && !ce) begin
                if (bits.size() == 18) begin
                    m_freq = take(4, 14); m_rsa = 1;
                end else if (bits.size() == 19) begin
                    m_freq = take(4, 15); m_rsa = 0;
                end else if (bits.size() == 27) begin
                    m_cp = int'(bits[20]); m_test = take(21, 3); m_rsa = int'(bits[24]);
                    m_rsb = int'(bits[25]); m_os = int'(bits[26]);
                end
            end
            if (bus_sel && ce && m_pscl && !scl) bits.push_back(sda);
            if (bus_sel && ce && !m_pscl && scl) begin
                rises++;
                if (rises == 5 && bits.size() >= 4)  m_band = take(0, 4);
                if (rises == 20 && bits.size() >= 19) m_freq = take(4, 15);
            end
            if (!(bus_sel && ce)) begin bits.delete(); rises = 0; end
            m_pce  = bus_sel && ce;
            m_pscl = scl;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R2 band", int'(band_sw), m_band);
        chk("R5 divider", int'(freq_word), m_freq);
        chk("R6 pump", int'(pump_hi), m_cp);
        chk("R6 test", int'(test_mode), m_test);
        chk("R3 ratio_a", int'(ratio_a), m_rsa);
        chk("R7 ratio_b", int'(ratio_b), m_rsb);
        chk("R6 tune_off", int'(tune_off), m_os);
        chk("R10 wire_mode", int'(wire_mode), int'(bus_sel));
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            if (rst_n) compare_model();
        end
    endtask

    task automatic send_bit(bit b);
        sda = b; tick(1); scl = 1; tick(2); scl = 0; tick(1);
    endtask

    task automatic send_word(logic [31:0] w, int len);
        ce = 1; tick(2);
        for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
        ce = 0; tick(2);
    endtask

    initial begin
        logic [26:0] ext;
        tick(4);
        rst_n = 1;
        tick(1);
        // R1 R11: reset state
        chk("R1 band", int'(band_sw), 0);
        chk("R1 divider", int'(freq_word), 0);
        chk("R1 pump/test/tune", int'({pump_hi, test_mode, tune_off}), 5'b1_001_1);
        chk("R11 ratio_b", int'(ratio_b), 1);
        chk("R1 ratio_a", int'(ratio_a), 0);

        // R4 R2: 19-bit frame
        send_word({13'd0, 4'b0010, 15'h2A5C}, 19);
        chk("R2 band 19b", int'(band_sw), 4'b0010);
        chk("R4 divider", int'(freq_word), 15'h2A5C);
        chk("R4 ratio_a", int'(ratio_a), 0);

        // R5 R6: 27-bit frame, divider loads at 20th rise before close
        ext = {4'b0001, 15'h0280, 8'h94};
        ce = 1; tick(2);
        for (int i = 26; i >= 8; i--) send_bit(ext[i]);
        chk("R5 divider before 20th rise", int'(freq_word), 15'h2A5C);
        sda = ext[7]; tick(1); scl = 1; tick(1);
        chk("R5 divider at 20th rise", int'(freq_word), 15'h0280);
        chk("R5 pump unchanged mid-frame", int'(pump_hi), 1);
        tick(1); scl = 0; tick(1);
        for (int i = 6; i >= 0; i--) send_bit(ext[i]);
        ce = 0; tick(2);
        chk("R6 pump", int'(pump_hi), 0);
        chk("R6 test", int'(test_mode), 3'b010);
        chk("R6 ratio_a/ratio_b/tune_off", int'({ratio_a, ratio_b, tune_off}), 3'b100);

        // R3 R7: 18-bit frame keeps extended fields
        send_word({14'd0, 4'b1000, 14'h1F0F}, 18);
        chk("R3 divider", int'(freq_word), 15'h1F0F);
        chk("R3 ratio_a", int'(ratio_a), 1);
        chk("R7 kept fields", int'({pump_hi, test_mode, ratio_b, tune_off}), 6'b0_010_0_0);

        // R4: top divider bit honoured in 19-bit frame
        send_word({13'd0, 4'b0100, 15'h7001}, 19);
        chk("R4 divider msb", int'(freq_word), 15'h7001);
        chk("R7 pump kept", int'(pump_hi), 0);

        // R8: short frames
        send_word({22'd0, 4'b1111, 6'h2A}, 10);
        chk("R8 band loads", int'(band_sw), 4'hF);
        chk("R8 divider kept", int'(freq_word), 15'h7001);
        send_word({29'd0, 3'b101}, 3);
        chk("R8 band kept on 3-bit frame", int'(band_sw), 4'hF);

        // R9: 22-bit frame
        send_word({10'd0, 4'b0011, 15'h0555, 3'b111}, 22);
        chk("R9 band", int'(band_sw), 4'b0011);
        chk("R9 divider from 20th rise", int'(freq_word), 15'h0555);
        chk("R9 ratio_a kept", int'(ratio_a), 0);
        chk("R9 control kept", int'({pump_hi, test_mode}), 4'b0_010);

        // R10: deselected
        bus_sel = 0;
        send_word({13'd0, 4'b1001, 15'h1111}, 19);
        chk("R10 wire_mode", int'(wire_mode), 0);
        chk("R10 band", int'(band_sw), 4'b0011);
        chk("R10 divider", int'(freq_word), 15'h0555);
        bus_sel = 1; tick(2);

        // R6 R7: second extended frame then 18-bit frame keeps ratio_b
        send_word({5'd0, 4'b0001, 15'h0100, 8'hCB}, 27);
        chk("R6 control 2", int'({pump_hi, test_mode, ratio_a, ratio_b, tune_off}), 7'b1_001_011);
        send_word({14'd0, 4'b0001, 14'h0200}, 18);
        chk("R7 ratio_b kept", int'(ratio_b), 1);
        chk("R3 ratio_a set", int'(ratio_a), 1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule